// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a synthesizable behavioural model of a single-port synchronous static memory with a 32-bit word made of four byte lanes. Address, write data, chip enables, burst controls and write controls are all captured on the rising clock edge. A read registers the addressed word at that edge and presents it straight away, so the data for an access is visible during the cycle that follows the edge which accepted it.

Two strobes can open an access. One is read-only and the other may write. After either strobe, an advance input steps a 2-bit burst counter. The counter forms the two low address bits in linear or interleaved order, and a mode pin chooses the order. Bursts are optional, because a new external address can be loaded on every edge. An output enable and a sleep input gate the output without waiting for a clock. The bidirectional data bus is split into a write-data input, a read-data output and an output-valid flag.

Top module: `sync_burst_sram`

## Requirements
- R1: A selected read accepted at a rising edge drives `rvalid` high and `rdata` to the stored word, starting right after that edge and lasting until the next edge.
- R2: The controller strobe `cstb` with no write control asserted performs a read, exactly as the processor strobe `pstb` does.
- R3: The burst counter steps only at an edge where `adv` is high and a burst is open. An edge with neither strobe nor `adv` leaves the counter unchanged and drives `rvalid` low for the following cycle.
- R4: When `burst_ilv` is 0, the k-th advanced address keeps the upper bits of the start address. Its two low bits equal (start[1:0] + k) mod 4.
- R5: When `burst_ilv` is 1, the k-th advanced address keeps the upper bits of the start address. Its two low bits equal start[1:0] XOR (k mod 4).
- R6: Strobes on consecutive edges with different addresses each return valid data in the cycle that follows, with no idle cycle between them.
- R7: A write with `bw_en` high and `gw` low updates exactly the lanes whose `byte_sel` bit is 1. Bit i selects `wdata[8i+7:8i]`. All other lanes keep their contents.
- R8: `gw` high on a writing access updates all four lanes, whatever `bw_en` and `byte_sel` are.
- R9: An access opened by `pstb` is a read even when `gw` or `bw_en` is high, and memory is left unchanged. `pstb` wins when both strobes are high.
- R10: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe while the device is deselected gives `rvalid` low and closes the burst, so a later `adv` has no effect.
- R11: `oe` low forces `rvalid` low and `rdata` to zero at once, without a clock edge. Raising `oe` again restores the held read data.
- R12: While `sleep` is high, `rvalid` is low at once and all commands, including writes, are ignored. Memory contents are kept. The first edge after `sleep` falls accepts commands again.
- R13: After reset, `rvalid` is low and every word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| wdata | input | 32 | Write data, four byte lanes |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| pstb | input | 1 | Processor strobe: opens a read-only access |
| cstb | input | 1 | Controller strobe: opens a read or write access |
| adv | input | 1 | Advance the burst counter |
| bw_en | input | 1 | Byte-write enable |
| byte_sel | input | 4 | Per-lane write selects |
| gw | input | 1 | Global write, all lanes |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous low-power hold |
| rdata | output | 32 | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid (data bus driven) |

## Verification
The hardest situations to reach are a burst that continues after an idle edge and a burst that a deselected strobe has closed. In both, the counter state can only be seen through the address an `adv` reads later. The bench therefore gives every word a distinct arithmetic pattern. It opens a burst, inserts an idle edge or a deselected strobe, and then issues `adv`, so the data returned, or its absence, identifies the counter value. It sweeps every start address in both orders through a full counter wrap. It also applies every `byte_sel` pattern against a shadow memory.

// File: rtl/sburst_pkg.sv
package sburst_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int DATA_W = BYTE_W * LANES;
    localparam int CNT_W  = 2;

    typedef enum logic {
        ORDER_LIN = 1'b0,
        ORDER_ILV = 1'b1
    } order_e;
endpackage

// File: rtl/sburst_seq_addr.sv
module sburst_seq_addr
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  step,
    input  order_e            order,
    output logic [ADDR_W-1:0] addr
);
    logic [CNT_W-1:0] low;

    always_comb begin
        if (order == ORDER_ILV) begin
            low = base[CNT_W-1:0] ^ step;
        end else begin
            low = base[CNT_W-1:0] + step;
        end
        addr = {base[ADDR_W-1:CNT_W], low};
    end
endmodule

// File: rtl/sburst_lane_mask.sv
module sburst_lane_mask
    import sburst_pkg::*;
(
    input  logic             gw,
    input  logic             bw_en,
    input  logic [LANES-1:0] sel,
    output logic [LANES-1:0] mask
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign mask[l] = gw | (bw_en & sel[l]);
    end
endmodule

// File: rtl/sburst_array.sv
module sburst_array
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rdata = mem_q[addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) begin
                mem_q[w] <= '0;
            end
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_we[l]) begin
                    mem_q[addr][l*BYTE_W +: BYTE_W] <= wdata[l*BYTE_W +: BYTE_W];
                end
            end
        end
    end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sburst_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              pstb,
    input  logic              cstb,
    input  logic              adv,
    input  logic              bw_en,
    input  logic [3:0]        byte_sel,
    input  logic              gw,
    input  logic              burst_ilv,
    input  logic              oe,
    input  logic              sleep,
    output logic [31:0]       rdata,
    output logic              rvalid
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        logic              active;
        logic              rd;
        logic [DATA_W-1:0] data;
    } state_t;

    state_t st_d, st_q;

    logic              is_sel, any_stb, start, drop, step;
    logic [ADDR_W-1:0] gen_base, acc_addr;
    logic [CNT_W-1:0]  gen_step;
    logic [LANES-1:0]  mask, lane_we;
    logic [DATA_W-1:0] arr_rdata;

    assign is_sel  = !ce1_n && ce2 && !ce3_n;
    assign any_stb = pstb || cstb;
    assign start   = !sleep && any_stb && is_sel;
    assign drop    = !sleep && any_stb && !is_sel;
    assign step    = !sleep && !any_stb && adv && st_q.active;

    assign gen_base = start ? addr : st_q.base;
    assign gen_step = start ? '0 : st_q.cnt + 1'b1;

    sburst_seq_addr #(.ADDR_W(ADDR_W)) i_seq (
        .base  (gen_base),
        .step  (gen_step),
        .order (order_e'(burst_ilv)),
        .addr  (acc_addr)
    );

    sburst_lane_mask i_mask (
        .gw    (gw),
        .bw_en (bw_en),
        .sel   (byte_sel),
        .mask  (mask)
    );

    sburst_array #(.ADDR_W(ADDR_W)) i_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (acc_addr),
        .lane_we (lane_we),
        .wdata   (wdata),
        .rdata   (arr_rdata)
    );

    always_comb begin
        st_d = st_q;
        // writes allowed on controller-strobe starts and on advance steps
        lane_we = (step || (start && !pstb)) ? mask : '0;
        st_d.rd   = (start || step) && (lane_we == '0);
        st_d.data = arr_rdata;
        if (start) begin
            st_d.base   = addr;
            st_d.cnt    = '0;
            st_d.active = 1'b1;
        end else if (drop) begin
            st_d.active = 1'b0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rvalid = st_q.rd && oe && !sleep;
    assign rdata  = rvalid ? st_q.data : '0;

    p_hold_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !adv && !any_stb && !sleep) |=> $stable(st_q.cnt));
    p_pstb_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pstb && is_sel && !sleep) |-> (lane_we == '0));
    p_gw_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gw && cstb && !pstb && is_sel && !sleep) |-> (&lane_we));
    p_desel_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (any_stb && !is_sel && !sleep) |=> (!st_q.active && !rvalid));
    p_oe_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (rdata == '0));
    p_sleep_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (lane_we == '0));
    p_sleep_norw_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !st_q.rd);
endmodule

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic          pstb = 1'b0, cstb = 1'b0, adv = 1'b0;
    logic          bw_en = 1'b0, gw = 1'b0, burst_ilv = 1'b0;
    logic [3:0]    byte_sel = '0;
    logic          oe = 1'b1, sleep = 1'b0;
    logic [31:0]   rdata;
    logic          rvalid;

    int checks = 0, errors = 0;
    logic [31:0] model [DEPTH];

    always #2.5 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW)) i_sync_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .pstb(pstb), .cstb(cstb),
        .adv(adv), .bw_en(bw_en), .byte_sel(byte_sel), .gw(gw),
        .burst_ilv(burst_ilv), .oe(oe), .sleep(sleep),
        .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [31:0] pat(int a, int salt);
        return (32'(a) * 32'h01030507) ^ (32'(salt) * 32'h1F2E3D4C) ^ 32'hC0DE0000;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        pstb = 0; cstb = 0; adv = 0; gw = 0; bw_en = 0; byte_sel = '0;
        ce1_n = 0; ce2 = 1; ce3_n = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic expect_read(string req, logic [31:0] exp);
        chk(rvalid === 1'b1 && rdata === exp, req, rdata, exp);
    endtask

    task automatic expect_none(string req);
        chk(rvalid === 1'b0, req, {31'd0, rvalid}, 32'd0);
    endtask

    function automatic int seq_addr(int s, int k, bit ilv);
        int lo = ilv ? ((s & 3) ^ (k & 3)) : (((s & 3) + k) & 3);
        return (s & ~3) | lo;
    endfunction

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) model[a] = '0;
        #1;
        expect_none("R13 reset");
        @(posedge clk); #1; rst_n = 1;
        // R13: memory cleared
        addr = 0; pstb = 1; tick(); expect_read("R13 zero word", 32'd0);

        // fill memory with global writes via controller strobe
        for (int a = 0; a < DEPTH; a++) begin
            addr = AW'(a); wdata = pat(a, 0); cstb = 1; gw = 1; tick();
            model[a] = pat(a, 0);
            expect_none("R8 write cycle no output");
        end
        // R1 R6: back-to-back reads of all addresses
        for (int a = 0; a < DEPTH; a++) begin
            addr = AW'(DEPTH - 1 - a); pstb = 1; tick();
            expect_read("R1 R6 back-to-back read", model[DEPTH - 1 - a]);
        end
        // R2: controller strobe read
        addr = 7; cstb = 1; tick(); expect_read("R2 cstb read", model[7]);

        // R4 R5: bursts from every start in both orders, full wrap
        for (int o = 0; o < 2; o++) begin
            burst_ilv = o[0];
            for (int s = 0; s < DEPTH; s++) begin
                addr = AW'(s); pstb = 1; tick();
                expect_read(o ? "R5 start" : "R4 start", model[s]);
                for (int k = 1; k <= 4; k++) begin
                    adv = 1; tick();
                    expect_read(o ? "R5 interleaved step" : "R4 linear step",
                                model[seq_addr(s, k, o[0])]);
                end
            end
        end
        burst_ilv = 0;

        // R3: idle edge holds counter
        addr = 8; pstb = 1; tick();
        adv = 1; tick(); expect_read("R3 step", model[9]);
        tick(); expect_none("R3 idle no output");
        adv = 1; tick(); expect_read("R3 resume", model[10]);

        // R7: every byte_sel pattern
        for (int m = 0; m < 16; m++) begin
            logic [31:0] nd = pat(m, 5);
            addr = 5; wdata = nd; cstb = 1; bw_en = 1; byte_sel = 4'(m); tick();
            for (int l = 0; l < 4; l++)
                if (m[l]) model[5][l*8 +: 8] = nd[l*8 +: 8];
            addr = 5; pstb = 1; tick(); expect_read("R7 byte lanes", model[5]);
        end
        // R8: global write overrides narrow byte select
        addr = 6; wdata = pat(6, 9); cstb = 1; bw_en = 1; byte_sel = 4'b0001; gw = 1; tick();
        model[6] = pat(6, 9);
        addr = 6; pstb = 1; tick(); expect_read("R8 global write", model[6]);
        // R7 R8: writes on an advance step
        addr = 12; pstb = 1; tick();
        adv = 1; gw = 1; wdata = pat(13, 3); tick(); model[13] = pat(13, 3);
        expect_none("R8 advance write");
        addr = 13; pstb = 1; tick(); expect_read("R8 advance write data", model[13]);

        // R9: processor strobe ignores write controls, wins over cstb
        addr = 2; wdata = 32'hDEADBEEF; pstb = 1; cstb = 1; gw = 1; tick();
        expect_read("R9 pstb read despite gw", model[2]);
        addr = 2; pstb = 1; tick(); expect_read("R9 memory unchanged", model[2]);

        // R10: each enable violation closes the burst
        for (int e = 0; e < 3; e++) begin
            addr = 4; pstb = 1; tick();
            addr = 0; pstb = 1;
            if (e == 0) ce1_n = 1; else if (e == 1) ce2 = 0; else ce3_n = 1;
            tick(); expect_none("R10 deselected strobe");
            adv = 1; tick(); expect_none("R10 adv after close");
        end

        // R11: asynchronous output enable
        addr = 3; pstb = 1; tick(); expect_read("R11 before", model[3]);
        oe = 0; #0.5;
        chk(rvalid === 0 && rdata === 0, "R11 oe low", rdata, 32'd0);
        oe = 1; #0.5; expect_read("R11 oe restored", model[3]);

        // R12: sleep
        sleep = 1; #0.5; expect_none("R12 async sleep");
        #0.5;
        addr = 3; wdata = 32'h12345678; cstb = 1; gw = 1; tick();
        expect_none("R12 asleep");
        addr = 3; pstb = 1; tick();
        expect_none("R12 read ignored");
        sleep = 0;
        addr = 3; pstb = 1; tick(); expect_read("R12 contents kept, resume", model[3]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule